// File: doc/BRIEF.md
# Endian-Configurable Load/Store Lane Aligner

This block sits between a 32-bit register datapath and a 32-bit data memory port and does the byte-lane steering that memory accesses need. A store request carries a register value, an access size (byte, half-word or full word), the two low address bits and an endian-mode bit. The block replicates the value across the lanes it could occupy. It then asserts byte enables only on the lanes that the size, offset and endian mode select. A load request carries the memory word that was read. The block picks out the addressed byte or half-word, sign-extends it and returns a full 32-bit result.

The block is a single registered stage. A request is accepted when `req_valid` and `req_ready` are both high. The store lanes, the byte enables and the misalignment pulse appear in the cycle after acceptance. A load result is held behind a valid/ready handshake until the register side takes it. Accesses that are not naturally aligned are flagged and produce no lane enables and no load result.

Top module: `lsu_lane_aligner`

## Requirements
- R1: For a byte access at offset o, exactly one byte enable is set: bit 3-o in big-endian mode (`big_endian`=1) and bit o in little-endian mode. Enable bit i governs `st_lanes[8i+7:8i]`.
- R2: For a half-word access, the enables are 4'b1100 at offset 0 and 4'b0011 at offset 2 in big-endian mode. In little-endian mode they are 4'b0011 at offset 0 and 4'b1100 at offset 2.
- R3: A full-word access at offset 0 sets all four enables, and `st_lanes` carries the register value unchanged.
- R4: The block raises `misaligned` for exactly one cycle, the cycle after acceptance, in three cases: a half-word access with offset bit 0 set, a full-word access with a non-zero offset, and the reserved size code 3. Such an access sets no byte enable and returns no load result. Size codes are 0 for byte, 1 for half-word, 2 for full word.
- R5: On a store, a byte value is copied into all four lanes and a half-word value into both halves of `st_lanes`.
- R6: A byte load returns the byte in the lane given by R1, sign-extended from its bit 7.
- R7: A half-word load returns the 16 bits in the lanes given by R2 (the higher lane is the upper byte), sign-extended from bit 15.
- R8: A full-word load returns the memory word unchanged.
- R9: `req_ready` equals `!ld_valid || ld_ready`. While `ld_valid` is high and `ld_ready` is low, `ld_valid` and `ld_data` stay unchanged and no new request is accepted.
- R10: While reset is asserted and in the first cycle after it, `ld_valid`, `misaligned` and `st_byte_en` are all zero.
- R11: Byte enables, store lanes and load results appear one cycle after acceptance. `st_byte_en` is zero in every cycle that does not follow an accepted aligned store.
- R12: The endian bit is sampled only when a request is accepted. Changing `big_endian` or `mem_rdata` while a load result is held does not alter `ld_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half-word, 2 full word, 3 reserved |
| req_ofs | input | 2 | Low address bits of the access |
| big_endian | input | 1 | 1 = big-endian lane order, 0 = little-endian |
| st_wdata | input | 32 | Register value to store |
| mem_rdata | input | 32 | Memory word read for a load, valid with the request |
| st_lanes | output | 32 | Store data placed in memory lanes |
| st_byte_en | output | 4 | Per-lane write enables |
| misaligned | output | 1 | One-cycle misaligned-access pulse |
| ld_valid | output | 1 | Load result available |
| ld_ready | input | 1 | Register side takes the load result |
| ld_data | output | 32 | Sign-extended load result |

## Verification
The bench sweeps every combination of size code, offset and endian mode, once as a store and once as a load. This separates a swapped lane order from a mirrored half-word choice, and tells the reserved size code apart from an ordinary misalignment. The memory words use distinct byte values with the top bit set in some lanes and clear in others, so a wrong lane or a zero extension shows up as a different result. A back-pressure phase holds a load while it flips the endian bit and changes the memory word, which separates sampling at acceptance from sampling later. A long random phase with a random `ld_ready` mixes stores, loads and stalls back to back, which exposes wrong acceptance or clearing of the held result.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_HALF = 2'd1,
      ACC_FULL = 2'd2,
      ACC_RSVD = 2'd3
   } acc_size_e;

endpackage

// File: rtl/lane_select.sv
module lane_select
   import lane_align_pkg::*;
#(
   parameter int NLANES = 4,
   parameter int OFS_W  = 2
) (
   input  acc_size_e              size_i,
   input  logic [OFS_W-1:0]       ofs_i,
   input  logic                   big_i,
   output logic [NLANES-1:0]      en_o,
   output logic [OFS_W-1:0]       byte_lane_o,
   output logic [OFS_W-1:0]       half_lane_o,
   output logic                   misalign_o
);

   // Big-endian mirrors the offset: lane = NLANES-1-ofs, which is ~ofs
   // for a power-of-two lane count. The half-word low lane is the even one.
   always_comb begin
      byte_lane_o = big_i ? ~ofs_i : ofs_i;
      half_lane_o = {byte_lane_o[OFS_W-1:1], 1'b0};
   end

   always_comb begin
      unique case (size_i)
         ACC_BYTE: misalign_o = 1'b0;
         ACC_HALF: misalign_o = ofs_i[0];
         ACC_FULL: misalign_o = |ofs_i;
         default:  misalign_o = 1'b1;
      endcase
   end

   for (genvar l = 0; l < NLANES; l++) begin : g_lane_en
      localparam logic [OFS_W-1:0] LANE_ID = OFS_W'(l);
      always_comb begin
         en_o[l] = 1'b0;
         if (!misalign_o) begin
            unique case (size_i)
               ACC_BYTE: en_o[l] = (byte_lane_o == LANE_ID);
               ACC_HALF: en_o[l] = (half_lane_o[OFS_W-1:1] == LANE_ID[OFS_W-1:1]);
               ACC_FULL: en_o[l] = 1'b1;
               default:  en_o[l] = 1'b0;
            endcase
         end
      end
   end

endmodule

// File: rtl/store_replicate.sv
module store_replicate
   import lane_align_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int NLANES = 4,
   localparam int DATA_W = LANE_W * NLANES
) (
   input  acc_size_e           size_i,
   input  logic [DATA_W-1:0]   data_i,
   output logic [DATA_W-1:0]   lanes_o
);

   for (genvar l = 0; l < NLANES; l++) begin : g_lane
      localparam int HALF_SRC = (l % 2) * LANE_W;
      localparam int FULL_SRC = l * LANE_W;
      always_comb begin
         unique case (size_i)
            ACC_BYTE: lanes_o[l*LANE_W +: LANE_W] = data_i[LANE_W-1:0];
            ACC_HALF: lanes_o[l*LANE_W +: LANE_W] = data_i[HALF_SRC +: LANE_W];
            default:  lanes_o[l*LANE_W +: LANE_W] = data_i[FULL_SRC +: LANE_W];
         endcase
      end
   end

endmodule

// File: rtl/load_extract.sv
module load_extract
   import lane_align_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int NLANES = 4,
   parameter int OFS_W  = 2,
   localparam int DATA_W = LANE_W * NLANES,
   localparam int HALF_W = 2 * LANE_W
) (
   input  acc_size_e           size_i,
   input  logic [OFS_W-1:0]    byte_lane_i,
   input  logic [OFS_W-1:0]    half_lane_i,
   input  logic [DATA_W-1:0]   mem_i,
   output logic [DATA_W-1:0]   data_o
);

   logic [LANE_W-1:0] byte_val;
   logic [HALF_W-1:0] half_val;

   // Lane multiplexers built as explicit one-hot OR trees.
   always_comb begin
      byte_val = '0;
      half_val = '0;
      for (int l = 0; l < NLANES; l++) begin
         if (byte_lane_i == OFS_W'(l))
            byte_val = byte_val | mem_i[l*LANE_W +: LANE_W];
      end
      for (int h = 0; h < NLANES / 2; h++) begin
         if (half_lane_i == OFS_W'(2 * h))
            half_val = half_val | mem_i[h*HALF_W +: HALF_W];
      end
   end

   always_comb begin
      unique case (size_i)
         ACC_BYTE: data_o = {{(DATA_W-LANE_W){byte_val[LANE_W-1]}}, byte_val};
         ACC_HALF: data_o = {{(DATA_W-HALF_W){half_val[HALF_W-1]}}, half_val};
         default:  data_o = mem_i;
      endcase
   end

endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
   import lane_align_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int NLANES = DATA_W / LANE_W,
   localparam int OFS_W  = $clog2(NLANES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_store,
   input  logic [1:0]           req_size,
   input  logic [OFS_W-1:0]     req_ofs,
   input  logic                 big_endian,
   input  logic [DATA_W-1:0]    st_wdata,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic [DATA_W-1:0]    st_lanes,
   output logic [NLANES-1:0]    st_byte_en,
   output logic                 misaligned,
   output logic                 ld_valid,
   input  logic                 ld_ready,
   output logic [DATA_W-1:0]    ld_data
);

   if ((DATA_W % LANE_W) != 0) begin : g_bad_split
      $error("DATA_W must be a whole number of lanes");
   end
   if (NLANES < 4 || (NLANES & (NLANES - 1)) != 0) begin : g_bad_lanes
      $error("lane count must be a power of two of at least four");
   end

   acc_size_e            size_e;
   logic [NLANES-1:0]    en_c;
   logic [OFS_W-1:0]     byte_lane_c, half_lane_c;
   logic                 mis_c;
   logic [DATA_W-1:0]    lanes_c, ext_c;
   logic                 accept;

   assign size_e    = acc_size_e'(req_size);
   assign req_ready = !ld_valid || ld_ready;
   assign accept    = req_valid && req_ready;

   lane_select #(.NLANES(NLANES), .OFS_W(OFS_W)) u_sel (
      .size_i      (size_e),
      .ofs_i       (req_ofs),
      .big_i       (big_endian),
      .en_o        (en_c),
      .byte_lane_o (byte_lane_c),
      .half_lane_o (half_lane_c),
      .misalign_o  (mis_c)
   );

   store_replicate #(.LANE_W(LANE_W), .NLANES(NLANES)) u_rep (
      .size_i  (size_e),
      .data_i  (st_wdata),
      .lanes_o (lanes_c)
   );

   load_extract #(.LANE_W(LANE_W), .NLANES(NLANES), .OFS_W(OFS_W)) u_ext (
      .size_i      (size_e),
      .byte_lane_i (byte_lane_c),
      .half_lane_i (half_lane_c),
      .mem_i       (mem_rdata),
      .data_o      (ext_c)
   );

   // Store side: enables pulse for one cycle, lanes hold between stores.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_byte_en <= '0;
         misaligned <= 1'b0;
         st_lanes   <= '0;
      end else begin
         st_byte_en <= (accept && req_store) ? en_c : '0;
         misaligned <= accept && mis_c;
         if (accept && req_store && !mis_c)
            st_lanes <= lanes_c;
      end
   end

   // Load return: captured at acceptance, held until taken.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_valid <= 1'b0;
         ld_data  <= '0;
      end else if (accept) begin
         ld_valid <= !req_store && !mis_c;
         if (!req_store && !mis_c)
            ld_data <= ext_c;
      end else if (ld_ready) begin
         ld_valid <= 1'b0;
      end
   end

   a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !ld_ready) |=> (ld_valid && $stable(ld_data)));

   a_r4_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      misaligned |-> (st_byte_en == '0 && !ld_valid));

   a_r11_pulse_only_after_store: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready && req_store) |=> (st_byte_en == '0));

   a_r2_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(st_byte_en) == 0 || $countones(st_byte_en) == 1 ||
       $countones(st_byte_en) == 2 || $countones(st_byte_en) == NLANES));

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (misaligned && !(req_valid && req_ready)) |=> !misaligned);

   a_r12_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !ld_ready) |-> !req_ready);

endmodule

// File: tb/tb_lsu_lane_aligner.sv
module tb_lsu_lane_aligner;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_store = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [1:0]  req_ofs = 2'd0;
   logic        big_endian = 1'b0;
   logic [31:0] st_wdata = '0;
   logic [31:0] mem_rdata = '0;
   logic [31:0] st_lanes;
   logic [3:0]  st_byte_en;
   logic        misaligned;
   logic        ld_valid;
   logic        ld_ready = 1'b1;
   logic [31:0] ld_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lsu_lane_aligner dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_store(req_store), .req_size(req_size), .req_ofs(req_ofs),
      .big_endian(big_endian), .st_wdata(st_wdata), .mem_rdata(mem_rdata),
      .st_lanes(st_lanes), .st_byte_en(st_byte_en), .misaligned(misaligned),
      .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data)
   );

   // ---------------- reference model ----------------
   logic        m_ldv = 1'b0, m_mis = 1'b0;
   logic [3:0]  m_be = '0;
   logic [31:0] m_st = '0, m_ld = '0;
   string       m_be_tag = "R11", m_ld_tag = "R8";

   function automatic bit is_bad(input logic [1:0] sz, input logic [1:0] o);
      if (sz == 2'd0) return 1'b0;
      if (sz == 2'd1) return o[0];
      if (sz == 2'd2) return o != 2'd0;
      return 1'b1;
   endfunction

   function automatic int byte_lane(input logic [1:0] o, input logic be);
      return be ? 3 - int'(o) : int'(o);
   endfunction

   function automatic int half_lo(input logic [1:0] o, input logic be);
      return be ? 2 - int'(o) : int'(o);
   endfunction

   always @(posedge clk) begin
      bit acc;
      logic [31:0] w;
      if (!rst_n) begin
         m_ldv = 1'b0; m_mis = 1'b0; m_be = '0; m_st = '0; m_ld = '0;
      end else begin
         acc = req_valid && (!m_ldv || ld_ready);
         m_be = '0; m_mis = 1'b0; m_be_tag = "R11";
         if (acc) begin
            if (is_bad(req_size, req_ofs)) begin
               m_mis = 1'b1; m_be_tag = "R4"; m_ldv = 1'b0;
            end else if (req_store) begin
               m_ldv = 1'b0;
               case (req_size)
                  2'd0: begin m_be = 4'(1 << byte_lane(req_ofs, big_endian));
                        m_st = {4{st_wdata[7:0]}}; m_be_tag = "R1"; end
                  2'd1: begin m_be = 4'(3 << half_lo(req_ofs, big_endian));
                        m_st = {2{st_wdata[15:0]}}; m_be_tag = "R2"; end
                  default: begin m_be = 4'hF; m_st = st_wdata; m_be_tag = "R3"; end
               endcase
            end else begin
               m_ldv = 1'b1;
               case (req_size)
                  2'd0: begin w = mem_rdata >> (8 * byte_lane(req_ofs, big_endian));
                        m_ld = {{24{w[7]}}, w[7:0]}; m_ld_tag = "R6"; end
                  2'd1: begin w = mem_rdata >> (8 * half_lo(req_ofs, big_endian));
                        m_ld = {{16{w[15]}}, w[15:0]}; m_ld_tag = "R7"; end
                  default: begin m_ld = mem_rdata; m_ld_tag = "R8"; end
               endcase
            end
         end else if (ld_ready) begin
            m_ldv = 1'b0;
         end else if (m_ldv) begin
            m_ld_tag = "R12";
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R9 ready", {31'd0, req_ready}, {31'd0, !m_ldv || ld_ready});
         check("R9 ld_valid", {31'd0, ld_valid}, {31'd0, m_ldv});
         check({m_be_tag, " byte_en"}, {28'd0, st_byte_en}, {28'd0, m_be});
         check("R4 misaligned", {31'd0, misaligned}, {31'd0, m_mis});
         if (m_be != 4'd0) check("R5 st_lanes", st_lanes, m_st);
         if (m_ldv) check({m_ld_tag, " ld_data"}, ld_data, m_ld);
      end
   end

   // ---------------- stimulus ----------------
   task automatic access(input bit st, input logic [1:0] sz, input logic [1:0] o,
                         input bit be, input logic [31:0] d, input logic [31:0] m);
      @(posedge clk); #1;
      req_valid = 1'b1; req_store = st; req_size = sz; req_ofs = o;
      big_endian = be; st_wdata = d; mem_rdata = m;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10 ld_valid in reset", {31'd0, ld_valid}, 32'd0);
      check("R10 byte_en in reset", {28'd0, st_byte_en}, 32'd0);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      check("R10 misaligned after reset", {31'd0, misaligned}, 32'd0);

      // sweep all sizes, offsets, modes
      for (int be = 0; be < 2; be++)
         for (int sz = 0; sz < 4; sz++)
            for (int o = 0; o < 4; o++) begin
               access(1'b1, 2'(sz), 2'(o), 1'(be), 32'hA5C3_7E81, 32'h0);
               access(1'b0, 2'(sz), 2'(o), 1'(be), 32'h0, 32'h8A3B_F1_4C);
               access(1'b0, 2'(sz), 2'(o), 1'(be), 32'h0, 32'h1977_26E0);
            end

      // directed R12: hold a load while endian and memory change
      @(posedge clk); #1; ld_ready = 1'b0;
      access(1'b0, 2'd0, 2'd1, 1'b1, 32'h0, 32'h11F2_3344);
      req_valid = 1'b1; req_store = 1'b1; req_size = 2'd2; req_ofs = 2'd0;
      big_endian = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R12 held byte", ld_data, 32'hFFFF_FFF2);
      check("R9 blocked", {31'd0, req_ready}, 32'd0);
      #1 req_valid = 1'b0; ld_ready = 1'b1;

      // random mix with back-pressure
      for (int i = 0; i < 3000; i++) begin
         @(posedge clk); #1;
         req_valid  = ($urandom % 4) != 0;
         req_store  = $urandom % 2;
         req_size   = 2'($urandom % 4);
         req_ofs    = 2'($urandom % 4);
         big_endian = $urandom % 2;
         st_wdata   = $urandom;
         mem_rdata  = $urandom;
         ld_ready   = ($urandom % 10) < 7;
      end
      @(posedge clk); #1; req_valid = 1'b0; ld_ready = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule